// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. A system clock samples the bus clock and data lines through synchronizer flops. Start and stop conditions are detected from the synchronized samples. The block checks a device header against a fixed code and three strap inputs. It takes in a two-byte word address and then reads or writes a byte array that sits outside the block, behind a simple memory port. The data line is driven only through an open-drain enable. When the enable is high, the line is pulled low.

One address counter persists from one transaction to the next. Writes advance the counter inside the current 32-byte page. Reads advance it across the whole array. From these rules the block supports byte writes, page writes, current-address reads, random reads (a write header and address, then a repeated start) and sequential reads that continue for as long as the master acknowledges. The memory port is combinational on the read side: `mem_rdata` must show the byte at `mem_addr` in the same cycle. A write is a single-cycle strobe.

Top module: `tws_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start condition, and a rising data line while the clock line is high is a stop condition. Either one releases the data line on the next cycle. A start always begins reception of a new device header.
- R2: The header byte is received MSB first. Its bits 7..4 must be 1010 and its bits 3..1 must equal `chip_sel[2:0]`. Bit 0 set means read. On a mismatch the block sends no acknowledge, ignores all traffic until the next start, and leaves the address counter unchanged.
- R3: Each byte the block receives (header, address bytes, data) is acknowledged by pulling the data line low while the clock is high on the ninth clock.
- R4: After a write header, the next two bytes form the word address, high byte first. Address bits at or above the array's address width are ignored.
- R5: Each data byte after the word address produces exactly one `mem_we` strobe, at the counter's address. The counter then advances only in its low 5 bits, so the address wraps to the start of the same 32-byte page.
- R6: A read header with no preceding word address returns the byte at the counter. The counter always holds the last accessed address plus one.
- R7: A write header and word address, then a repeated start and a read header, return the byte at the loaded address.
- R8: During a read, a master acknowledge (low) makes the block send the next byte, and a master no-acknowledge ends the transfer until a stop or start.
- R9: The read address advances past the last array byte to byte 0.
- R10: A start that arrives partway through a byte discards that byte. Nothing is written, and the counter keeps its value.
- R11: The block turns on its data-line drive only while the synchronized clock line is low, and it does not drive during the master's acknowledge slot.
- R12: After reset the data line is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| chip_sel | input | 3 | Strap value that header bits 3..1 must match |
| sda_oe | output | 1 | Open-drain enable; 1 pulls the data line low |
| mem_we | output | 1 | Single-cycle write strobe to the array |
| mem_addr | output | log2(MEM_BYTES) | Array address (the internal counter) |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Array byte at `mem_addr`, combinational |

## Verification
Two cases are the hardest to reach from the pins. The first is a start that arrives partway through a data byte. To produce it, the stimulus clocks four bits of a data byte after a valid address, raises the data line while the clock is low, and then forms a start. A following current-address read shows whether that byte or the counter was disturbed. The second is a sequential read that runs across the end of the array, so that both the array rollover and the page wrap are visible. It is reached by loading an address two bytes below the top of the array, placed after a page write that wrapped into byte 0.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } tws_state_e;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [SYNC_STAGES:0] scl_sh;
  logic [SYNC_STAGES:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  // newest synchronized sample and the one before it
  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  =  scl_sh[SYNC_STAGES-1] & ~scl_sh[SYNC_STAGES];
  assign scl_fall  = ~scl_sh[SYNC_STAGES-1] &  scl_sh[SYNC_STAGES];
  assign start_evt =  scl_sh[SYNC_STAGES-1] & scl_sh[SYNC_STAGES]
                   &  sda_sh[SYNC_STAGES] & ~sda_sh[SYNC_STAGES-1];
  assign stop_evt  =  scl_sh[SYNC_STAGES-1] & scl_sh[SYNC_STAGES]
                   & ~sda_sh[SYNC_STAGES] &  sda_sh[SYNC_STAGES-1];

endmodule

// File: rtl/tws_addr_ctr.sv
module tws_addr_ctr #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          wr_step,
  input  logic          rd_step,
  output logic [AW-1:0] addr
);

  // write stepping keeps the page row, wraps the column
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:PW], PW'(a[PW-1:0] + 1'b1)};
  endfunction

  // read stepping runs through the whole array
  function automatic logic [AW-1:0] lin_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_val;
    else if (wr_step) addr <= page_step(addr);
    else if (rd_step) addr <= lin_step(addr);
  end

endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave #(
  parameter int MEM_BYTES   = 4096,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  input  logic [2:0]                   chip_sel,
  output logic                         sda_oe,
  output logic                         mem_we,
  output logic [$clog2(MEM_BYTES)-1:0] mem_addr,
  output logic [7:0]                   mem_wdata,
  input  logic [7:0]                   mem_rdata
);
  import tws_pkg::*;

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = AW - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  tws_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tws_state_e    state_q, ret_q;
  logic [7:0]    shreg_q;
  logic [3:0]    bitcnt_q;
  logic [HW-1:0] hi_q;
  logic          oe_q;
  logic          mack_q;

  // named internal events
  logic rx_state, byte_done, dev_match, dev_reject, addr_load, wr_commit, rd_load;
  logic [AW-1:0] ctr;

  assign rx_state   = (state_q == ST_DEV) || (state_q == ST_AHI)
                   || (state_q == ST_ALO) || (state_q == ST_WDAT);
  assign byte_done  = rx_state && scl_fall && (bitcnt_q == 4'd8);
  assign dev_match  = (shreg_q[7:4] == DEV_CODE) && (shreg_q[3:1] == chip_sel);
  assign dev_reject = byte_done && (state_q == ST_DEV) && !dev_match;
  assign addr_load  = byte_done && (state_q == ST_ALO);
  assign wr_commit  = byte_done && (state_q == ST_WDAT);
  assign rd_load    = scl_fall && (((state_q == ST_ACK) && (ret_q == ST_TX))
                                || ((state_q == ST_MACK) && mack_q));

  tws_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val({hi_q, shreg_q}),
    .wr_step(wr_commit), .rd_step(rd_load), .addr(ctr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ret_q    <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      hi_q     <= '0;
      oe_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else if (start_evt) begin
      state_q  <= ST_DEV;
      bitcnt_q <= '0;
      oe_q     <= 1'b0;
    end else if (stop_evt) begin
      state_q  <= ST_IDLE;
      oe_q     <= 1'b0;
    end else if (rd_load) begin
      shreg_q  <= mem_rdata;
      oe_q     <= ~mem_rdata[7];
      bitcnt_q <= 4'd1;
      state_q  <= ST_TX;
    end else if (byte_done) begin
      oe_q    <= 1'b1;
      state_q <= ST_ACK;
      unique case (state_q)
        ST_DEV: begin
          if (dev_match) ret_q <= shreg_q[0] ? ST_TX : ST_AHI;
          else begin
            oe_q    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_AHI: begin
          hi_q  <= shreg_q[HW-1:0];
          ret_q <= ST_ALO;
        end
        default: ret_q <= ST_WDAT;
      endcase
    end else begin
      unique case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (scl_rise && bitcnt_q != 4'd8) begin
            shreg_q  <= {shreg_q[6:0], sda_s};
            bitcnt_q <= bitcnt_q + 4'd1;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_q     <= 1'b0;
            bitcnt_q <= '0;
            state_q  <= ret_q;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              oe_q     <= ~shreg_q[6];
              shreg_q  <= {shreg_q[6:0], 1'b0};
              bitcnt_q <= bitcnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_q <= ~sda_s;
          if (scl_fall) state_q <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe    = oe_q;
  assign mem_we    = wr_commit;
  assign mem_wdata = shreg_q;
  assign mem_addr  = ctr;

endmodule

// File: rtl/tws_mem_slave_chk.sv
module tws_mem_slave_chk #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          rd_load,
  input logic          dev_reject
);

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> !sda_oe); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_evt |=> !sda_oe); // R1
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) dev_reject |=> !sda_oe); // R2
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R5
  AST_WE_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr[PW-1:0] == PW'($past(mem_addr[PW-1:0]) + 1'b1))
            && (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW]))); // R5
  AST_RD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> mem_addr == AW'($past(mem_addr) + 1'b1)); // R9
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s); // R11

endmodule

bind tws_mem_slave tws_mem_slave_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .mem_we(mem_we),
  .mem_addr(mem_addr), .start_evt(start_evt), .stop_evt(stop_evt),
  .rd_load(rd_load), .dev_reject(dev_reject)
);

// File: tb/tb_tws_mem_slave.sv
module tb_tws_mem_slave;

  localparam int MEM  = 4096;
  localparam int AW   = 12;
  localparam int PAGE = 32;
  localparam int Q    = 6;
  localparam logic [7:0] DEV_W = 8'hAA;   // 1010, chip_sel 101, write
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, m_scl, m_sda;
  logic sda_oe, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_bus = m_sda & ~sda_oe;

  logic [7:0] mem [MEM];
  int ref_mem [MEM];
  int ref_ctr;
  int exp_wa[$];
  int exp_wd[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  tws_mem_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .chip_sel(3'b101),
    .sda_oe(sda_oe), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of write strobes against the model queue (R5)
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_wa.size() == 0) chk(1'b0, "R5 unexpected write", int'(mem_addr), -1);
      else begin
        chk(int'(mem_addr) == exp_wa[0] && int'(mem_wdata) == exp_wd[0],
            "R5 write addr/data", int'({mem_addr, mem_wdata}), (exp_wa[0] << 8) | exp_wd[0]);
        void'(exp_wa.pop_front());
        void'(exp_wd.pop_front());
      end
      mem[mem_addr] <= mem_wdata;
    end
  end

  function automatic int page_next(input int a);
    return (a & ~(PAGE - 1)) | ((a + 1) & (PAGE - 1));
  endfunction

  task automatic model_wr(input int d);
    exp_wa.push_back(ref_ctr);
    exp_wd.push_back(d);
    ref_mem[ref_ctr] = d;
    ref_ctr = page_next(ref_ctr);
  endtask

  task automatic model_rd(output int e);
    e = ref_mem[ref_ctr];
    ref_ctr = (ref_ctr + 1) % MEM;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic clk_bit(input bit b, output bit seen);
    m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); seen = sda_bus; m_scl = 1'b0; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] v, output bit oe_ack);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    m_sda = !mack; wt(Q); m_scl = 1'b1; wt(Q); oe_ack = sda_oe; m_scl = 1'b0; wt(Q);
    m_sda = 1'b1;
  endtask

  task automatic set_addr(input int a, output bit ok);
    bit k1, k2, k3;
    bus_start;
    put_byte(DEV_W, k1);
    put_byte(8'(a >> 8), k2);
    put_byte(8'(a), k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic read_one(input string req, input bit mack);
    logic [7:0] v;
    bit oe;
    int e;
    get_byte(mack, v, oe);
    model_rd(e);
    chk(int'(v) == e, req, int'(v), e);
    chk(!oe, "R11 released in master ack slot", int'(oe), 0);
  endtask

  initial begin
    bit ok, ack;
    for (int i = 0; i < MEM; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = (i * 7 + 3) & 255;
    end
    ref_ctr = 0;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    wt(5);
    chk(!sda_oe && !mem_we, "R12 reset state", int'({sda_oe, mem_we}), 0);
    rst_n = 1'b1;
    wt(5);

    // byte write
    set_addr(16'h0123, ok);
    ref_ctr = 16'h0123;
    chk(ok, "R3 header and address acks", int'(ok), 1);
    model_wr(8'h5A);
    put_byte(8'h5A, ack);
    chk(ack, "R3 data ack", int'(ack), 1);
    bus_stop;

    // random read
    set_addr(16'h0123, ok);
    ref_ctr = 16'h0123;
    bus_start;
    put_byte(DEV_R, ack);
    chk(ack, "R2 read header ack", int'(ack), 1);
    read_one("R7 random read data", 1'b0);
    bus_stop;

    // current address read
    bus_start;
    put_byte(DEV_R, ack);
    read_one("R6 current address read", 1'b0);
    bus_stop;

    // page write wrapping inside the page
    set_addr(16'h001E, ok);
    ref_ctr = 16'h001E;
    for (int i = 0; i < 4; i++) begin
      model_wr(8'hA0 + i);
      put_byte(8'(8'hA0 + i), ack);
      chk(ack, "R3 page data ack", int'(ack), 1);
    end
    bus_stop;
    set_addr(16'h0000, ok);
    ref_ctr = 0;
    bus_start;
    put_byte(DEV_R, ack);
    read_one("R5 page wrap landed at byte 0", 1'b1);
    read_one("R5 page wrap landed at byte 1", 1'b0);
    bus_stop;

    // sequential read across the array end
    set_addr(MEM - 2, ok);
    ref_ctr = MEM - 2;
    bus_start;
    put_byte(DEV_R, ack);
    read_one("R8 sequential byte 0", 1'b1);
    read_one("R8 sequential byte 1", 1'b1);
    read_one("R9 rollover to byte 0", 1'b1);
    read_one("R9 rollover byte 1", 1'b0);
    chk(!sda_oe, "R8 no drive after nack", int'(sda_oe), 0);
    bus_stop;
    bus_start;
    put_byte(DEV_R, ack);
    read_one("R6 counter after sequential read", 1'b0);
    bus_stop;

    // unused upper word-address bits
    set_addr(16'hF140, ok);
    ref_ctr = 16'h0140;
    model_wr(8'h77);
    put_byte(8'h77, ack);
    bus_stop;
    set_addr(16'h0140, ok);
    ref_ctr = 16'h0140;
    bus_start;
    put_byte(DEV_R, ack);
    read_one("R4 upper address bits ignored", 1'b0);
    bus_stop;

    // header mismatch: wrong strap, then wrong code
    bus_start;
    put_byte(8'hA6, ack);
    chk(!ack, "R2 strap mismatch no ack", int'(ack), 0);
    put_byte(8'h00, ack);
    chk(!ack, "R2 ignored after mismatch", int'(ack), 0);
    put_byte(8'h99, ack);
    chk(!ack, "R2 ignored data", int'(ack), 0);
    bus_stop;
    bus_start;
    put_byte(8'hBA, ack);
    chk(!ack, "R2 code mismatch no ack", int'(ack), 0);
    bus_stop;
    bus_start;
    put_byte(DEV_R, ack);
    read_one("R2 counter kept after mismatch", 1'b0);
    bus_stop;

    // start in the middle of a data byte
    set_addr(16'h0200, ok);
    ref_ctr = 16'h0200;
    begin
      bit s;
      clk_bit(1'b0, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    end
    bus_start;
    put_byte(DEV_R, ack);
    chk(ack, "R1 start re-enters header reception", int'(ack), 1);
    read_one("R10 aborted byte not written", 1'b0);
    bus_stop;

    wt(20);
    chk(exp_wa.size() == 0, "R5 all expected writes seen", exp_wa.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule